// File: doc/BRIEF.md
# Content-Protection Receiver Register File

This block is the byte-wide register space that a link content-protection receiver presents to the upstream transmitter over a sideband channel. The transmitter reads the receiver key vector, the 16-bit response value, the five 32-bit hash words, the capability, status and topology bytes, and a key-vector list window. It writes its own 40-bit key vector and the 64-bit session random number. Writing the last random-number byte issues a one-cycle start pulse to the authentication engine. The cipher engine, the hash engine and the key store sit outside the block and supply their results on plain input ports.

Sideband accesses use a request stream and a response stream, both valid/ready. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. A read returns one byte on the response stream. A write returns nothing. `req_ready` is low only while an earlier read response is still waiting with `rsp_ready` low. In that state the response byte is held unchanged and no new request is accepted.

A local host works through a 32-bit control and status pair. Writing the control word clears the interrupt flag, rewinds the list-window offset, or forces the block out of the authenticated state. The status word reports the authenticated state and the interrupt flag.

Top module: `cprx_regfile`

## Requirements
- R1: After reset, `rsp_valid`, `tx_ksv`, `sess_rand`, `auth_start`, `irq_flag` and `authenticated` are all 0, and the host status word reads 0.
- R2: A read of sideband address 0x00+k (k=0..4) returns `rx_ksv[8k+7:8k]`. A read of 0x05+k (k=0..1) returns `resp_val[8k+7:8k]`.
- R3: A write of byte d to 0x07+k (k=0..4) sets `tx_ksv[8k+7:8k]`=d. A write to 0x0C+k (k=0..7) sets `sess_rand[8k+7:8k]`=d. Each write takes effect on the accepting edge. Reads of 0x07..0x13 and of unmapped addresses (0x2D..0x3F) return 0x00.
- R4: `auth_start` is high for exactly one cycle after an accepted write to 0x13. Writes to any other address leave it low.
- R5: A read of 0x14+k (k=0..19) returns `hash_words[8k+7:8k]`, so word Hn is `hash_words[32n+31:32n]`, low byte first.
- R6: 0x28 reads {6'b0, repeater, 1'b1}. 0x29 reads {4'b0, reauth_req, link_fail, resp_avail, link_ready}. 0x2A reads {max_devs, dev_count}. 0x2B reads {4'b0, max_casc, depth}.
- R7: Writes to read-only addresses (0x00..0x06, 0x14..0x2C) change nothing: later reads return the input-driven values, and a write to 0x2C does not move the list offset.
- R8: With `repeater`=1, each read of 0x2C returns byte `ksv_list[8i+7:8i]`, where i is the current offset, and then increments the offset. The offset saturates at L=5*min(dev_count,MAX_DEV)-1 and does not wrap. If dev_count is 0, reads return 0x00.
- R9: With `repeater`=0, every read of 0x2C returns 0x00 and the offset does not move.
- R10: A host write to 0x3E with bit 29 set resets the offset to 0. This wins over a 0x2C read in the same cycle, and that read still returns the byte at the old offset.
- R11: The `irq_event` pulse sets `irq_flag`. A host write to 0x3E with bit 30 set clears it. A set wins over a clear in the same cycle. Host status word 0x3F bit 18 reflects `irq_flag`.
- R12: The `auth_done` pulse sets `authenticated`. A host write to 0x3E with bit 28 set clears it, and the exit wins when both occur in the same cycle. Host status bit 19 reflects it, and every other status bit reads 0.
- R13: `req_ready` = !rsp_valid || rsp_ready. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` are held. A read accepted on the edge where the old response is taken produces the new response with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Sideband request valid |
| req_ready | output | 1 | Sideband request ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Sideband byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response ready |
| rsp_data | output | 8 | Read response byte |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 6 | Host address (0x3E control, 0x3F status) |
| host_wdata | input | 32 | Host control word |
| host_rdata | output | 32 | Host read data (status at 0x3F, else 0) |
| rx_ksv | input | 40 | Receiver key vector |
| resp_val | input | 16 | Authentication response value |
| resp_avail | input | 1 | Response-available status bit |
| link_ready | input | 1 | List-ready status bit |
| link_fail | input | 1 | Link integrity failure status bit |
| reauth_req | input | 1 | Re-authentication request status bit |
| repeater | input | 1 | Repeater capability flag |
| hash_words | input | 160 | Hash words H0..H4 |
| dev_count | input | 7 | Downstream device count |
| max_devs | input | 1 | Device limit exceeded |
| depth | input | 3 | Cascade depth |
| max_casc | input | 1 | Cascade limit exceeded |
| ksv_list | input | 40*MAX_DEV | Downstream key vectors, byte 0 first |
| irq_event | input | 1 | Interrupt event pulse |
| auth_done | input | 1 | Authentication success pulse |
| tx_ksv | output | 40 | Transmitter key vector written over sideband |
| sess_rand | output | 64 | Session random number written over sideband |
| auth_start | output | 1 | One-cycle engine start pulse |
| irq_flag | output | 1 | Interrupt-status flag |
| authenticated | output | 1 | Authenticated state |

## Verification
The hardest states to reach are the collisions: a list-window read landing on the same edge as a host rewind, and an interrupt set or authentication exit landing on the same edge as its opposite. The bench drives both ports inside the same clock period to create them. Saturation is reached by sweeping the device count from 0 up past the storage limit. Each sweep reads a few bytes beyond the last valid one and checks the repeated final byte. Back-pressure is exercised by holding `rsp_ready` low across several cycles with a second request waiting, then releasing it.

// File: rtl/cprx_pkg.sv
package cprx_pkg;
  localparam int ADDR_W     = 6;
  localparam int BYTE_W     = 8;
  localparam int KSV_BYTES  = 5;
  localparam int RESP_BYTES = 2;
  localparam int AN_BYTES   = 8;
  localparam int HASH_BYTES = 20;
  localparam int HOST_W     = 32;

  localparam logic [ADDR_W-1:0] A_RXKSV = 6'h00;
  localparam logic [ADDR_W-1:0] A_RESP  = 6'h05;
  localparam logic [ADDR_W-1:0] A_TXKSV = 6'h07;
  localparam logic [ADDR_W-1:0] A_RAND  = 6'h0C;
  localparam logic [ADDR_W-1:0] A_RLAST = 6'h13;
  localparam logic [ADDR_W-1:0] A_HASH  = 6'h14;
  localparam logic [ADDR_W-1:0] A_CAPS  = 6'h28;
  localparam logic [ADDR_W-1:0] A_LSTAT = 6'h29;
  localparam logic [ADDR_W-1:0] A_TOPO0 = 6'h2A;
  localparam logic [ADDR_W-1:0] A_TOPO1 = 6'h2B;
  localparam logic [ADDR_W-1:0] A_LISTW = 6'h2C;
  localparam logic [ADDR_W-1:0] A_HCTRL = 6'h3E;
  localparam logic [ADDR_W-1:0] A_HSTAT = 6'h3F;

  localparam int CB_IRQ_CLR = 30;
  localparam int CB_REWIND  = 29;
  localparam int CB_EXIT    = 28;
  localparam int SB_AUTH    = 19;
  localparam int SB_IRQ     = 18;

  typedef struct packed {
    logic reauth;
    logic fail;
    logic avail;
    logic ready;
  } link_stat_t;

  typedef struct packed {
    logic       devs_over;
    logic [6:0] count;
    logic       casc_over;
    logic [2:0] depth;
  } topo_t;
endpackage

// File: rtl/cprx_wr_regs.sv
module cprx_wr_regs
  import cprx_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [BYTE_W-1:0]            wr_data,
  output logic [KSV_BYTES*BYTE_W-1:0]  tx_ksv,
  output logic [AN_BYTES*BYTE_W-1:0]   sess_rand,
  output logic                         start
);
  for (genvar k = 0; k < KSV_BYTES; k++) begin : g_ksv
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        tx_ksv[k*BYTE_W +: BYTE_W] <= '0;
      else if (wr_en && wr_addr == (A_TXKSV + 6'(k)))
        tx_ksv[k*BYTE_W +: BYTE_W] <= wr_data;
    end
  end

  for (genvar k = 0; k < AN_BYTES; k++) begin : g_rand
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        sess_rand[k*BYTE_W +: BYTE_W] <= '0;
      else if (wr_en && wr_addr == (A_RAND + 6'(k)))
        sess_rand[k*BYTE_W +: BYTE_W] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start <= 1'b0;
    else        start <= wr_en && (wr_addr == A_RLAST);
  end
endmodule

// File: rtl/cprx_list_window.sv
module cprx_list_window
  import cprx_pkg::*;
#(
  parameter int MAX_DEV = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         pop,
  input  logic                         rewind,
  input  logic                         repeater,
  input  logic [6:0]                   dev_count,
  input  logic [MAX_DEV*KSV_BYTES*BYTE_W-1:0] list,
  output logic [BYTE_W-1:0]            cur_byte
);
  localparam int LIST_BYTES = MAX_DEV * KSV_BYTES;
  localparam int OFS_W      = $clog2(LIST_BYTES);

  logic [OFS_W-1:0] offset;
  logic [OFS_W-1:0] sel;
  int               cnt_eff;
  int               last_i;
  logic             enabled;
  logic             at_end;

  always_comb begin
    cnt_eff = (int'(dev_count) > MAX_DEV) ? MAX_DEV : int'(dev_count);
    last_i  = KSV_BYTES * cnt_eff - 1;
    enabled = repeater && (cnt_eff != 0);
    at_end  = int'(offset) >= last_i;
    sel     = at_end ? OFS_W'(last_i) : offset;
  end

  always_comb begin
    cur_byte = '0;
    for (int k = 0; k < LIST_BYTES; k++)
      if (enabled && sel == OFS_W'(k))
        cur_byte = list[k*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      offset <= '0;
    else if (rewind)
      offset <= '0;
    else if (pop && enabled && !at_end)
      offset <= offset + 1'b1;
  end
endmodule

// File: rtl/cprx_host_ctl.sv
module cprx_host_ctl
  import cprx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  input  logic              irq_event,
  input  logic              auth_done,
  output logic              irq_flag,
  output logic              authenticated,
  output logic              rewind
);
  logic ctrl_wr;
  logic irq_clr;
  logic exit_req;
  logic unused_wbits;

  assign ctrl_wr      = host_we && (host_addr == A_HCTRL);
  assign irq_clr      = ctrl_wr && host_wdata[CB_IRQ_CLR];
  assign exit_req     = ctrl_wr && host_wdata[CB_EXIT];
  assign rewind       = ctrl_wr && host_wdata[CB_REWIND];
  assign unused_wbits = ^{host_wdata[31], host_wdata[27:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         irq_flag <= 1'b0;
    else if (irq_event) irq_flag <= 1'b1;
    else if (irq_clr)   irq_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         authenticated <= 1'b0;
    else if (exit_req)  authenticated <= 1'b0;
    else if (auth_done) authenticated <= 1'b1;
  end

  always_comb begin
    host_rdata = '0;
    if (host_addr == A_HSTAT) begin
      host_rdata[SB_AUTH] = authenticated;
      host_rdata[SB_IRQ]  = irq_flag;
    end
  end
endmodule

// File: rtl/cprx_rd_mux.sv
module cprx_rd_mux
  import cprx_pkg::*;
(
  input  logic [ADDR_W-1:0]             addr,
  input  logic [KSV_BYTES*BYTE_W-1:0]   rx_ksv,
  input  logic [RESP_BYTES*BYTE_W-1:0]  resp_val,
  input  logic [HASH_BYTES*BYTE_W-1:0]  hash_words,
  input  logic                          repeater,
  input  link_stat_t                    lstat,
  input  topo_t                         topo,
  input  logic [BYTE_W-1:0]             list_byte,
  output logic [BYTE_W-1:0]             rdata
);
  always_comb begin
    rdata = '0;
    for (int k = 0; k < KSV_BYTES; k++)
      if (addr == (A_RXKSV + 6'(k))) rdata = rx_ksv[k*BYTE_W +: BYTE_W];
    for (int k = 0; k < RESP_BYTES; k++)
      if (addr == (A_RESP + 6'(k))) rdata = resp_val[k*BYTE_W +: BYTE_W];
    for (int k = 0; k < HASH_BYTES; k++)
      if (addr == (A_HASH + 6'(k))) rdata = hash_words[k*BYTE_W +: BYTE_W];
    case (addr)
      A_CAPS:  rdata = {6'b0, repeater, 1'b1};
      A_LSTAT: rdata = {4'b0, lstat};
      A_TOPO0: rdata = {topo.devs_over, topo.count};
      A_TOPO1: rdata = {4'b0, topo.casc_over, topo.depth};
      A_LISTW: rdata = list_byte;
      default: ;
    endcase
  end
endmodule

// File: rtl/cprx_regfile.sv
module cprx_regfile
  import cprx_pkg::*;
#(
  parameter int MAX_DEV = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic                            req_write,
  input  logic [5:0]                      req_addr,
  input  logic [7:0]                      req_wdata,
  output logic                            rsp_valid,
  input  logic                            rsp_ready,
  output logic [7:0]                      rsp_data,
  input  logic                            host_we,
  input  logic [5:0]                      host_addr,
  input  logic [31:0]                     host_wdata,
  output logic [31:0]                     host_rdata,
  input  logic [39:0]                     rx_ksv,
  input  logic [15:0]                     resp_val,
  input  logic                            resp_avail,
  input  logic                            link_ready,
  input  logic                            link_fail,
  input  logic                            reauth_req,
  input  logic                            repeater,
  input  logic [159:0]                    hash_words,
  input  logic [6:0]                      dev_count,
  input  logic                            max_devs,
  input  logic [2:0]                      depth,
  input  logic                            max_casc,
  input  logic [MAX_DEV*40-1:0]           ksv_list,
  input  logic                            irq_event,
  input  logic                            auth_done,
  output logic [39:0]                     tx_ksv,
  output logic [63:0]                     sess_rand,
  output logic                            auth_start,
  output logic                            irq_flag,
  output logic                            authenticated
);
  logic              accept;
  logic              rd_acc;
  logic              wr_acc;
  logic              rewind;
  logic [BYTE_W-1:0] list_byte;
  logic [BYTE_W-1:0] mux_byte;
  link_stat_t        lstat;
  topo_t             topo;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign rd_acc    = accept && !req_write;
  assign wr_acc    = accept && req_write;

  assign lstat = '{reauth: reauth_req, fail: link_fail, avail: resp_avail, ready: link_ready};
  assign topo  = '{devs_over: max_devs, count: dev_count, casc_over: max_casc, depth: depth};

  cprx_wr_regs u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_acc),
    .wr_addr   (req_addr),
    .wr_data   (req_wdata),
    .tx_ksv    (tx_ksv),
    .sess_rand (sess_rand),
    .start     (auth_start)
  );

  cprx_list_window #(.MAX_DEV(MAX_DEV)) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .pop       (rd_acc && (req_addr == A_LISTW)),
    .rewind    (rewind),
    .repeater  (repeater),
    .dev_count (dev_count),
    .list      (ksv_list),
    .cur_byte  (list_byte)
  );

  cprx_host_ctl u_host (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_we       (host_we),
    .host_addr     (host_addr),
    .host_wdata    (host_wdata),
    .host_rdata    (host_rdata),
    .irq_event     (irq_event),
    .auth_done     (auth_done),
    .irq_flag      (irq_flag),
    .authenticated (authenticated),
    .rewind        (rewind)
  );

  cprx_rd_mux u_mux (
    .addr       (req_addr),
    .rx_ksv     (rx_ksv),
    .resp_val   (resp_val),
    .hash_words (hash_words),
    .repeater   (repeater),
    .lstat      (lstat),
    .topo       (topo),
    .list_byte  (list_byte),
    .rdata      (mux_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rd_acc) begin
      rsp_valid <= 1'b1;
      rsp_data  <= mux_byte;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cprx_regfile_chk.sv
module cprx_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic [5:0]  req_addr,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [7:0]  rsp_data,
  input logic        host_we,
  input logic [5:0]  host_addr,
  input logic [31:0] host_wdata,
  input logic        repeater,
  input logic        irq_event,
  input logic        auth_done,
  input logic        auth_start,
  input logic        irq_flag,
  input logic        authenticated
);
  // R13: a stalled response is held
  p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  // R13: no acceptance while a response is stalled
  p_stall_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  // R4: start is a single-cycle pulse
  p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    auth_start |=> !auth_start);

  // R4: start follows only a write to the last random byte
  p_start_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready && req_write && req_addr == 6'h13) |=> !auth_start);

  // R11: an event always sets the flag
  p_irq_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_event |=> irq_flag);

  // R12: exit always clears the state
  p_exit_r12: assert property (@(posedge clk) disable iff (!rst_n)
    host_we && host_addr == 6'h3E && host_wdata[28] |=> !authenticated);

  // R12: done without exit sets the state
  p_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    auth_done && !(host_we && host_addr == 6'h3E && host_wdata[28]) |=> authenticated);

  // R9: the list window reads zero for a non-repeater
  p_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write && req_addr == 6'h2C && !repeater |=> rsp_data == 8'h00);
endmodule

bind cprx_regfile cprx_regfile_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_write     (req_write),
  .req_addr      (req_addr),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_data      (rsp_data),
  .host_we       (host_we),
  .host_addr     (host_addr),
  .host_wdata    (host_wdata),
  .repeater      (repeater),
  .irq_event     (irq_event),
  .auth_done     (auth_done),
  .auth_start    (auth_start),
  .irq_flag      (irq_flag),
  .authenticated (authenticated)
);

// File: tb/tb_cprx_regfile.sv
module tb_cprx_regfile;
  localparam int MAXD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [5:0] req_addr = 0;
  logic [7:0] req_wdata = 0;
  logic req_ready, rsp_valid;
  logic [7:0] rsp_data;
  logic host_we = 0;
  logic [5:0] host_addr = 6'h3F;
  logic [31:0] host_wdata = 0;
  logic [31:0] host_rdata;
  logic [39:0] rx_ksv = 0;
  logic [15:0] resp_val = 0;
  logic resp_avail = 0, link_ready = 0, link_fail = 0, reauth_req = 0, repeater = 0;
  logic [159:0] hash_words = 0;
  logic [6:0] dev_count = 0;
  logic max_devs = 0, max_casc = 0;
  logic [2:0] depth = 0;
  logic [MAXD*40-1:0] ksv_list = 0;
  logic irq_event = 0, auth_done = 0;
  logic [39:0] tx_ksv;
  logic [63:0] sess_rand;
  logic auth_start, irq_flag, authenticated;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cprx_regfile #(.MAX_DEV(MAXD)) dut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int p, int k);
    return 8'(p * 37 + k * 11 + 3);
  endfunction

  task automatic sb_read(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(posedge clk); #2;
    req_valid = 0;
    d = rsp_data;
  endtask

  task automatic sb_write(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(posedge clk); #2;
    req_valid = 0; req_write = 0;
  endtask

  task automatic host_ctrl(input logic [31:0] w);
    @(negedge clk);
    host_we = 1; host_addr = 6'h3E; host_wdata = w;
    @(posedge clk); #2;
    host_we = 0; host_addr = 6'h3F; host_wdata = 0;
  endtask

  task automatic load_inputs(int p);
    for (int k = 0; k < 5; k++) rx_ksv[8*k +: 8] = pat(p, k);
    for (int k = 0; k < 2; k++) resp_val[8*k +: 8] = pat(p, k + 5);
    for (int k = 0; k < 20; k++) hash_words[8*k +: 8] = pat(p, k + 20);
    for (int k = 0; k < MAXD*5; k++) ksv_list[8*k +: 8] = pat(p, k + 50);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 tx_ksv", tx_ksv, 0);
    chk("R1 sess_rand", sess_rand, 0);
    chk("R1 auth_start", auth_start, 0);
    chk("R1 irq_flag", irq_flag, 0);
    chk("R1 authenticated", authenticated, 0);
    chk("R1 host status", host_rdata, 0);
    rst_n = 1;

    // R2, R5 sweeps over two patterns
    for (int p = 1; p < 3; p++) begin
      load_inputs(p);
      for (int k = 0; k < 7; k++) begin
        sb_read(6'(k), d);
        chk("R2 key/resp byte", d, pat(p, k < 5 ? k : k));
      end
      for (int k = 0; k < 20; k++) begin
        sb_read(6'(6'h14 + k), d);
        chk("R5 hash byte", d, pat(p, k + 20));
      end
    end

    // R6 capability, status, topology
    for (int r = 0; r < 2; r++) begin
      repeater = r[0];
      sb_read(6'h28, d);
      chk("R6 caps", d, {6'b0, r[0], 1'b1});
    end
    for (int s = 0; s < 16; s++) begin
      {reauth_req, link_fail, resp_avail, link_ready} = 4'(s);
      sb_read(6'h29, d);
      chk("R6 link status", d, 8'(s));
    end
    for (int t = 0; t < 6; t++) begin
      dev_count = 7'(t * 23); max_devs = t[0]; depth = 3'(t + 2); max_casc = t[1];
      sb_read(6'h2A, d);
      chk("R6 topo0", d, {t[0], 7'(t * 23)});
      sb_read(6'h2B, d);
      chk("R6 topo1", d, {4'b0, t[1], 3'(t + 2)});
    end

    // R3, R4 writes
    for (int k = 0; k < 13; k++) begin
      sb_write(6'(6'h07 + k), pat(7, k));
      chk("R4 start pulse", auth_start, (k == 12));
    end
    @(posedge clk); #2;
    chk("R4 start drops", auth_start, 0);
    for (int k = 0; k < 5; k++) chk("R3 tx_ksv byte", tx_ksv[8*k +: 8], pat(7, k));
    for (int k = 0; k < 8; k++) chk("R3 rand byte", sess_rand[8*k +: 8], pat(7, k + 5));
    for (int k = 0; k < 13; k++) begin
      sb_read(6'(6'h07 + k), d);
      chk("R3 write-only reads 0", d, 0);
    end
    for (int a = 6'h2D; a < 64; a++) begin
      sb_read(6'(a), d);
      chk("R3 unmapped reads 0", d, 0);
    end

    // R7 writes to read-only space; then list offset untouched
    repeater = 1; dev_count = 3;
    load_inputs(2);
    host_ctrl(32'h2000_0000);
    sb_write(6'h00, 8'hA5); sb_write(6'h05, 8'h5A); sb_write(6'h14, 8'h77);
    sb_write(6'h28, 8'hFF); sb_write(6'h2C, 8'h11); sb_write(6'h2C, 8'h22);
    sb_read(6'h00, d); chk("R7 key kept", d, pat(2, 0));
    sb_read(6'h05, d); chk("R7 resp kept", d, pat(2, 5));
    sb_read(6'h14, d); chk("R7 hash kept", d, pat(2, 20));
    sb_read(6'h28, d); chk("R7 caps kept", d, 8'h03);
    sb_read(6'h2C, d); chk("R7 offset unmoved", d, pat(2, 50));

    // R8 list window sweep with saturation and clamping
    for (int c = 0; c <= MAXD + 1; c++) begin
      int ce, last;
      dev_count = 7'(c);
      ce = (c > MAXD) ? MAXD : c;
      last = 5 * ce - 1;
      host_ctrl(32'h2000_0000);
      for (int i = 0; i < 5 * ce + 2; i++) begin
        sb_read(6'h2C, d);
        chk("R8 list byte", d, (ce == 0) ? 8'h00 : pat(2, 50 + ((i > last) ? last : i)));
      end
      if (ce == 0) begin
        sb_read(6'h2C, d);
        chk("R8 zero count", d, 0);
      end
    end

    // R9 non-repeater reads zero and keeps the offset
    dev_count = 2;
    host_ctrl(32'h2000_0000);
    repeater = 0;
    for (int i = 0; i < 3; i++) begin
      sb_read(6'h2C, d);
      chk("R9 non-repeater zero", d, 0);
    end
    repeater = 1;
    sb_read(6'h2C, d);
    chk("R9 offset held", d, pat(2, 50));

    // R10 rewind, and rewind colliding with a read
    sb_read(6'h2C, d); sb_read(6'h2C, d);
    chk("R10 advanced", d, pat(2, 52));
    host_ctrl(32'h2000_0000);
    sb_read(6'h2C, d);
    chk("R10 rewound", d, pat(2, 50));
    sb_read(6'h2C, d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 6'h2C;
    host_we = 1; host_addr = 6'h3E; host_wdata = 32'h2000_0000;
    @(posedge clk); #2;
    req_valid = 0; host_we = 0; host_addr = 6'h3F; host_wdata = 0;
    chk("R10 collide old byte", rsp_data, pat(2, 52));
    sb_read(6'h2C, d);
    chk("R10 collide rewinds", d, pat(2, 50));

    // R11 interrupt flag
    @(negedge clk); irq_event = 1;
    @(posedge clk); #2; irq_event = 0;
    chk("R11 set", irq_flag, 1);
    chk("R11 status bit", host_rdata, 32'h0004_0000);
    host_ctrl(32'h4000_0000);
    chk("R11 clear", irq_flag, 0);
    @(negedge clk);
    irq_event = 1; host_we = 1; host_addr = 6'h3E; host_wdata = 32'h4000_0000;
    @(posedge clk); #2;
    irq_event = 0; host_we = 0; host_addr = 6'h3F; host_wdata = 0;
    chk("R11 set wins", irq_flag, 1);
    host_ctrl(32'h4000_0000);

    // R12 authenticated state
    @(negedge clk); auth_done = 1;
    @(posedge clk); #2; auth_done = 0;
    chk("R12 set", authenticated, 1);
    chk("R12 status bit", host_rdata, 32'h0008_0000);
    host_ctrl(32'h1000_0000);
    chk("R12 exit", authenticated, 0);
    @(negedge clk); auth_done = 1;
    @(posedge clk); #2; auth_done = 0;
    @(negedge clk);
    auth_done = 1; host_we = 1; host_addr = 6'h3E; host_wdata = 32'h1000_0000;
    @(posedge clk); #2;
    auth_done = 0; host_we = 0; host_addr = 6'h3F; host_wdata = 0;
    chk("R12 exit wins", authenticated, 0);
    chk("R12 status idle", host_rdata, 0);

    // R13 back-pressure
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_write = 0; req_addr = 6'h00;
    @(posedge clk); #2;
    req_addr = 6'h01;
    chk("R13 rsp valid", rsp_valid, 1);
    chk("R13 ready low", req_ready, 0);
    repeat (2) @(posedge clk);
    #2;
    chk("R13 held valid", rsp_valid, 1);
    chk("R13 held data", rsp_data, pat(2, 0));
    @(negedge clk); rsp_ready = 1;
    #1; chk("R13 ready follows", req_ready, 1);
    @(posedge clk); #2;
    req_valid = 0;
    chk("R13 back-to-back valid", rsp_valid, 1);
    chk("R13 back-to-back data", rsp_data, pat(2, 1));
    @(posedge clk); #2;
    chk("R13 drains", rsp_valid, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule